// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the 32-bit program counter of a single-cycle core and decides, once per clock, where the next instruction is fetched from. It takes the low 26 bits of the current instruction word, the result of the register-equality comparison, the value read from a source register and a two-bit control code. From these it forms one of four next values: the following instruction, an equality branch target, a region-relative jump target, or a register-held address.

For the register-indirect jump with link, the block also presents the address of the following instruction as the link value. It raises a write strobe so the register file can store that value in the destination register. A stall input freezes the counter and suppresses the strobe, so a stalled cycle leaves no trace.

Top module: `pc_next_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) loads pc with 0x00000000, and reset takes priority over stall.
- R2: With control code 2'b00 (sequential) and no stall, pc becomes pc+4 at the next rising edge.
- R3: With control code 2'b01 (equality branch), eq high and no stall, pc becomes pc + 4 + (sign-extended instr_field[15:0] shifted left by 2).
- R4: With control code 2'b01, eq low and no stall, pc becomes pc+4.
- R5: With control code 2'b10 (region jump) and no stall, pc becomes {bits 31:28 of pc+4, instr_field[25:0], 2'b00}.
- R6: With control code 2'b11 (register jump with link) and no stall, pc becomes rs_val.
- R7: link_val always equals pc+4, and link_we is high exactly when the control code is 2'b11 and stall is low.
- R8: While stall is high and rst is low, pc keeps its value and link_we is low.
- R9: All additions wrap modulo 2^32, so pc 0xFFFFFFFC steps sequentially to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the counter for this cycle |
| ctrl | input | 2 | Next-address code: 00 sequential, 01 branch, 10 jump, 11 register jump with link |
| instr_field | input | 26 | Instruction bits 25:0; bits 15:0 are the branch offset |
| eq | input | 1 | Compared registers are equal |
| rs_val | input | 32 | Source register value for the register jump |
| pc | output | 32 | Current program counter |
| link_val | output | 32 | Return address, pc+4 |
| link_we | output | 1 | Write strobe for the return address |

## Verification
The properties take for granted that ctrl, eq, instr_field, rs_val and stall are settled before each rising edge and stay valid through it. They also assume that reset is applied for at least one edge before checking starts, so that every $past value lies after reset. The bench changes all inputs on the falling edge only and holds reset over two edges at the start. Random control codes, offsets, jump fields and register values then cover both signs of the offset and every stall combination. Directed cases reach the wrap point at 0xFFFFFFFC and a jump taken from the last word of a 256 MB region.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int XLEN   = 32;
  localparam int IMM_W  = 16;
  localparam int JIDX_W = 26;
  localparam int REGION = 4;
  localparam logic [XLEN-1:0] STEP = 32'd4;

  typedef enum logic [1:0] {
    NX_SEQ  = 2'b00,
    NX_BEQ  = 2'b01,
    NX_JMP  = 2'b10,
    NX_JREG = 2'b11
  } nx_code_e;

  function automatic logic [XLEN-1:0] f_seq(input logic [XLEN-1:0] cur);
    return cur + STEP;
  endfunction

  function automatic logic [XLEN-1:0] f_branch(input logic [XLEN-1:0] after,
                                               input logic [IMM_W-1:0] off);
    logic [XLEN-1:0] ext;
    ext = {{(XLEN-IMM_W){off[IMM_W-1]}}, off};
    return after + (ext << 2);
  endfunction

  function automatic logic [XLEN-1:0] f_jump(input logic [XLEN-1:0] after,
                                             input logic [JIDX_W-1:0] idx);
    return {after[XLEN-1 -: REGION], idx, 2'b00};
  endfunction

endpackage

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
(
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [JIDX_W-1:0] field,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   br_target,
  output logic [XLEN-1:0]   jmp_target
);

  always_comb begin
    seq_pc     = f_seq(cur_pc);
    br_target  = f_branch(seq_pc, field[IMM_W-1:0]);
    jmp_target = f_jump(seq_pc, field);
  end

endmodule

// File: rtl/pcu_select.sv
module pcu_select
  import pcu_pkg::*;
(
  input  logic [1:0]      ctrl,
  input  logic            eq,
  input  logic            stall,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] jmp_target,
  input  logic [XLEN-1:0] rs_val,
  output logic [XLEN-1:0] next_pc,
  output logic            br_taken,
  output logic            link_we
);

  nx_code_e code;

  always_comb begin
    code     = nx_code_e'(ctrl);
    br_taken = (code == NX_BEQ) && eq;
    link_we  = (code == NX_JREG) && !stall;
    if (stall) begin
      next_pc = cur_pc;
    end else begin
      unique case (code)
        NX_SEQ:  next_pc = seq_pc;
        NX_BEQ:  next_pc = br_taken ? br_target : seq_pc;
        NX_JMP:  next_pc = jmp_target;
        NX_JREG: next_pc = rs_val;
        default: next_pc = seq_pc;
      endcase
    end
  end

endmodule

// File: rtl/pcu_reg.sv
module pcu_reg
  import pcu_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] pc_q
);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= next_pc;
  end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stall,
  input  logic [1:0]  ctrl,
  input  logic [25:0] instr_field,
  input  logic        eq,
  input  logic [31:0] rs_val,
  output logic [31:0] pc,
  output logic [31:0] link_val,
  output logic        link_we
);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic [XLEN-1:0] next_pc;
  logic            br_taken;

  pcu_target u_tgt (
    .cur_pc     (pc),
    .field      (instr_field),
    .seq_pc     (seq_pc),
    .br_target  (br_target),
    .jmp_target (jmp_target)
  );

  pcu_select u_sel (
    .ctrl       (ctrl),
    .eq         (eq),
    .stall      (stall),
    .cur_pc     (pc),
    .seq_pc     (seq_pc),
    .br_target  (br_target),
    .jmp_target (jmp_target),
    .rs_val     (rs_val),
    .next_pc    (next_pc),
    .br_taken   (br_taken),
    .link_we    (link_we)
  );

  pcu_reg #(.RESET_PC(RESET_PC)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .next_pc (next_pc),
    .pc_q    (pc)
  );

  assign link_val = seq_pc;

endmodule

// File: rtl/pcu_chk.sv
module pcu_chk (
  input logic        clk,
  input logic        rst,
  input logic        stall,
  input logic [1:0]  ctrl,
  input logic        eq,
  input logic [31:0] rs_val,
  input logic [31:0] pc,
  input logic [31:0] seq_pc,
  input logic        br_taken,
  input logic        link_we
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> pc == 32'h0);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && ctrl == 2'b00) |=> pc == $past(seq_pc));

  // R4
  fallthru_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && ctrl == 2'b01 && !eq) |=> pc == $past(seq_pc));

  // R3
  taken_flag_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (ctrl == 2'b01 && eq));

  // R5
  region_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && ctrl == 2'b10) |=> (pc[31:28] == $past(seq_pc[31:28]) && pc[1:0] == 2'b00));

  // R6
  reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && ctrl == 2'b11) |=> pc == $past(rs_val));

  // R7
  link_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (ctrl == 2'b11 && !stall));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc));

endmodule

bind pc_next_unit pcu_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .stall    (stall),
  .ctrl     (ctrl),
  .eq       (eq),
  .rs_val   (rs_val),
  .pc       (pc),
  .seq_pc   (seq_pc),
  .br_taken (br_taken),
  .link_we  (link_we)
);

// File: tb/sim_pc_next_unit.sv
`timescale 1ns/1ps
module sim_pc_next_unit;

  logic        clk = 1'b0;
  logic        rst, stall, eq;
  logic [1:0]  ctrl;
  logic [25:0] instr_field;
  logic [31:0] rs_val, pc, link_val;
  logic        link_we;

  int tests = 0;
  int fails = 0;
  logic [31:0] model_pc;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pc_next_unit u0 (
    .clk(clk), .rst(rst), .stall(stall), .ctrl(ctrl),
    .instr_field(instr_field), .eq(eq), .rs_val(rs_val),
    .pc(pc), .link_val(link_val), .link_we(link_we)
  );

  function automatic logic [31:0] exp_next(input logic [31:0] p, input logic [1:0] c,
                                           input logic [25:0] f, input logic e,
                                           input logic [31:0] r, input logic s);
    logic [31:0] nxt;
    logic [31:0] off;
    nxt = p + 32'd4;
    off = {{14{f[15]}}, f[15:0], 2'b00};
    if (s) return p;
    case (c)
      2'b00: return nxt;
      2'b01: return e ? nxt + off : nxt;
      2'b10: return {nxt[31:28], f, 2'b00};
      default: return r;
    endcase
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [1:0] c, input logic [25:0] f,
                      input logic e, input logic [31:0] r, input logic s);
    ctrl = c; instr_field = f; eq = e; rs_val = r; stall = s;
    #1;
    check32("R7 link_val", link_val, model_pc + 32'd4);
    check32("R7 link_we", {31'd0, link_we}, {31'd0, (c == 2'b11) && !s});
    model_pc = exp_next(model_pc, c, f, e, r, s);
    @(posedge clk);
    @(negedge clk);
    check32(req, pc, model_pc);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; stall = 1'b1; ctrl = 2'b11; eq = 1'b0;
    instr_field = '0; rs_val = 32'h1234_5678;
    @(posedge clk); @(posedge clk); @(negedge clk);
    // R1: reset wins over stall and register jump
    check32("R1 reset", pc, 32'h0);
    rst = 1'b0;
    model_pc = 32'h0;

    step("R2 seq", 2'b00, 26'h0, 1'b0, 32'h0, 1'b0);
    step("R2 seq", 2'b00, 26'h3FFFFFF, 1'b1, 32'hFFFF, 1'b0);
    step("R3 fwd branch", 2'b01, 26'h0010, 1'b1, 32'h0, 1'b0);
    step("R3 back branch", 2'b01, 26'h0FFFE, 1'b1, 32'h0, 1'b0);
    step("R4 not taken", 2'b01, 26'h0040, 1'b0, 32'h0, 1'b0);
    step("R8 stall", 2'b11, 26'h0, 1'b1, 32'hDEAD_BEE0, 1'b1);
    step("R6 reg jump", 2'b11, 26'h0, 1'b0, 32'h8FFF_FFF8, 1'b0);
    step("R5 jump crosses region", 2'b00, 26'h0, 1'b0, 32'h0, 1'b0);
    step("R5 jump", 2'b10, 26'h2ABCDEF, 1'b0, 32'h0, 1'b0);
    step("R6 to top", 2'b11, 26'h0, 1'b0, 32'hFFFF_FFFC, 1'b0);
    step("R9 wrap", 2'b00, 26'h0, 1'b0, 32'h0, 1'b0);
    step("R6 to top", 2'b11, 26'h0, 1'b0, 32'hFFFF_FFFC, 1'b0);
    step("R9 branch wrap", 2'b01, 26'h00001, 1'b1, 32'h0, 1'b0);

    // R1: reset while stalled mid-run
    rst = 1'b1; stall = 1'b1;
    @(posedge clk); @(negedge clk);
    check32("R1 reset mid-run", pc, 32'h0);
    rst = 1'b0; model_pc = 32'h0;

    for (int i = 0; i < 400; i++) begin
      logic [1:0]  c;
      logic [25:0] f;
      logic        e, s;
      logic [31:0] r;
      c = 2'($urandom);
      f = 26'($urandom);
      e = 1'($urandom);
      s = ($urandom % 5) == 0;
      r = $urandom;
      step("R2-mix random", c, f, e, r, s);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule